// File: doc/BRIEF.md
# Strobed Handshake Port Group

This block is one group of a strobed parallel port. It owns an 8-bit data port and one active-low handshake pin from the peripheral, and it drives one flag pin back to the peripheral. When the group is strobed and set to input, the peripheral pulls the handshake pin low to capture its data in a latch. The block then holds an active-high buffer-full flag and raises an interrupt request until the host reads the byte. When the group is strobed and set to output, a completed host write latches the byte and pulls an active-low buffer-full pin low. The peripheral's acknowledge, on the same handshake pin, releases that pin and requests an interrupt.

The interrupt enable comes from the register unit as a level. The block produces a status byte and a position mask for the port C read-back path. Where the mask is set, the merge logic replaces the handshake pin levels with the status bits. The peripheral handshake pin is synchronised before use. Host read and write strobes are active-high levels in the block's clock domain. The block acts on their start and end edges. When the group is not strobed, reads pass the port pins straight through and writes drive the output latch.

Top module: `shp_group`

## Requirements
- R1: After synchronous reset, with the group not strobed and set to input, the flag pin is low, the interrupt is low and the status mask is 0x00.
- R2: In strobed input mode, a low handshake pin sets the flag pin (buffer full) on the third rising clock edge after the pin falls. The data sampled while the pin is seen low is held on the read data output after the port pins change.
- R3: Buffer full stays set during a host read and clears on the first clock edge after the host read strobe drops.
- R4: In strobed input mode, the interrupt rises once the handshake pin is high again with buffer full set and the enable high. It clears on the first clock edge after the host read strobe rises.
- R5: In strobed output mode, the first clock edge after the host write strobe drops pulls the flag pin (active-low buffer full) low. On that edge the port output shows the written byte, with the output enable high.
- R6: In strobed output mode, a low acknowledge returns the flag pin high on the third clock edge after it falls. The interrupt rises after the acknowledge is high again with the flag pin high and the enable high. It clears on the first clock edge after the host write strobe rises.
- R7: The interrupt output is low whenever the enable input is low. A strobe taken while the enable is low raises the interrupt once the enable is set.
- R8: Group A status (GROUP_A=1). For input, bit 5 is buffer full, bit 4 is the enable and bit 3 is the interrupt, with mask 0x38. For output, bit 7 is the active-low buffer-full pin, bit 6 is the enable and bit 3 is the interrupt, with mask 0xC8.
- R9: Group B status (GROUP_A=0). Bit 2 is the enable, bit 1 is the flag pin level and bit 0 is the interrupt, with mask 0x07.
- R10: Leaving strobed mode or changing direction clears buffer full and the interrupt and sets the active-low output flag high. The status mask is 0x00 while not strobed.
- R11: When not strobed, read data follows the port pins with no latching. The output enable is high exactly when the direction is output, driving the last written byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strobed | input | 1 | 1 selects strobed handshake operation |
| dir_in | input | 1 | 1 input direction, 0 output direction |
| intr_en | input | 1 | Interrupt enable from the register unit |
| host_rd | input | 1 | Active-high host read strobe for this port |
| host_wr | input | 1 | Active-high host write strobe for this port |
| host_wdata | input | 8 | Host write data |
| per_din | input | 8 | Port pin input levels |
| hs_n | input | 1 | Peripheral strobe (input) or acknowledge (output), active low |
| rd_data | output | 8 | Data returned on a host port read |
| port_out | output | 8 | Output latch value for the port pins |
| port_oe | output | 1 | Output enable for the port pins |
| flag_out | output | 1 | Buffer full (input) or active-low buffer full (output) |
| intr | output | 1 | Interrupt request |
| status_bits | output | 8 | Status byte for port C read-back |
| status_mask | output | 8 | Port C positions replaced by status_bits |

## Verification
Directed input sequences exercise a full strobe, release and read cycle. A sample of buffer full at the second and third edges after the strobe separates a correct synchroniser depth from an off-by-one. Reads are checked at both edges, which shows whether buffer full and the interrupt are tied to the correct end of the read. The output sequence, a write followed by an acknowledge, is checked the same way. A strobe taken with the enable low, followed by a late enable, tells level gating apart from edge capture. Two instances with different group layouts, a direction flip and a drop out of strobed mode expose misplaced status bits and flags that survive a configuration change.

// File: rtl/shp_pkg.sv
package shp_pkg;

    localparam int STAT_W = 8;

    localparam logic [STAT_W-1:0] MASK_A_IN  = 8'h38;
    localparam logic [STAT_W-1:0] MASK_A_OUT = 8'hC8;
    localparam logic [STAT_W-1:0] MASK_B     = 8'h07;

    typedef struct packed {
        logic flag;
        logic en;
        logic req;
    } hs_view_t;

    typedef struct packed {
        logic [STAT_W-1:0] bits;
        logic [STAT_W-1:0] mask;
    } stat_t;

    function automatic stat_t place_status(input logic group_a,
                                           input logic is_in,
                                           input hs_view_t v);
        stat_t s;
        s.bits = '0;
        s.mask = '0;
        if (group_a) begin
            if (is_in) begin
                s.bits[5] = v.flag;
                s.bits[4] = v.en;
                s.bits[3] = v.req;
                s.mask    = MASK_A_IN;
            end else begin
                s.bits[7] = v.flag;
                s.bits[6] = v.en;
                s.bits[3] = v.req;
                s.mask    = MASK_A_OUT;
            end
        end else begin
            s.bits[2] = v.en;
            s.bits[1] = v.flag;
            s.bits[0] = v.req;
            s.mask    = MASK_B;
        end
        return s;
    endfunction

endpackage

// File: rtl/shp_sync.sv
module shp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b1;
                    else     chain[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= 1'b1;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/shp_edge.sv
module shp_edge (
    input  logic clk,
    input  logic rst,
    input  logic lvl,
    output logic start,
    output logic stop,
    output logic busy
);
    logic lvl_q;

    always_ff @(posedge clk) begin
        if (rst) lvl_q <= 1'b0;
        else     lvl_q <= lvl;
    end

    assign start = lvl & ~lvl_q;
    assign stop  = ~lvl & lvl_q;
    assign busy  = lvl | lvl_q;
endmodule

// File: rtl/shp_in_hs.sv
module shp_in_hs #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              stb_low,
    input  logic              rd_start,
    input  logic              rd_stop,
    input  logic              rd_busy,
    input  logic              en,
    input  logic [DATA_W-1:0] din,
    output logic              ibf,
    output logic              req,
    output logic [DATA_W-1:0] latch
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ibf   <= 1'b0;
            req   <= 1'b0;
            latch <= '0;
        end else if (clr) begin
            ibf <= 1'b0;
            req <= 1'b0;
        end else begin
            if (stb_low) begin
                ibf   <= 1'b1;
                latch <= din;
            end else if (rd_stop) begin
                ibf <= 1'b0;
            end

            if (rd_start)
                req <= 1'b0;
            else if (!stb_low && ibf && en && !rd_busy)
                req <= 1'b1;
        end
    end

    assert_ibf_load_R2: assert property (@(posedge clk) disable iff (rst)
        (!clr && stb_low) |=> ibf);
    assert_ibf_drop_R3: assert property (@(posedge clk) disable iff (rst)
        (!clr && rd_stop && !stb_low) |=> !ibf);
    assert_req_clear_R4: assert property (@(posedge clk) disable iff (rst)
        rd_start |=> !req);
    assert_in_idle_R10: assert property (@(posedge clk) disable iff (rst)
        clr |=> (!ibf && !req));
endmodule

// File: rtl/shp_out_hs.sv
module shp_out_hs (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic ack_low,
    input  logic wr_start,
    input  logic wr_stop,
    input  logic wr_busy,
    input  logic en,
    output logic obf_n,
    output logic req
);
    always_ff @(posedge clk) begin
        if (rst) begin
            obf_n <= 1'b1;
            req   <= 1'b0;
        end else if (clr) begin
            obf_n <= 1'b1;
            req   <= 1'b0;
        end else begin
            if (wr_stop)
                obf_n <= 1'b0;
            else if (ack_low)
                obf_n <= 1'b1;

            if (wr_start)
                req <= 1'b0;
            else if (!ack_low && obf_n && en && !wr_busy)
                req <= 1'b1;
        end
    end

    assert_obf_low_R5: assert property (@(posedge clk) disable iff (rst)
        (!clr && wr_stop) |=> !obf_n);
    assert_obf_ack_R6: assert property (@(posedge clk) disable iff (rst)
        (!clr && ack_low && !wr_stop) |=> obf_n);
    assert_req_wr_R6: assert property (@(posedge clk) disable iff (rst)
        wr_start |=> !req);
    assert_out_idle_R10: assert property (@(posedge clk) disable iff (rst)
        clr |=> (obf_n && !req));
endmodule

// File: rtl/shp_group.sv
module shp_group #(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2,
    parameter bit GROUP_A     = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              strobed,
    input  logic              dir_in,
    input  logic              intr_en,
    input  logic              host_rd,
    input  logic              host_wr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic [DATA_W-1:0] per_din,
    input  logic              hs_n,
    output logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] port_out,
    output logic              port_oe,
    output logic              flag_out,
    output logic              intr,
    output logic [7:0]        status_bits,
    output logic [7:0]        status_mask
);
    import shp_pkg::*;

    logic mode_q, dir_q, cfg_chg;
    logic hs_sync, hs_low;
    logic rd_start, rd_stop, rd_busy;
    logic wr_start, wr_stop, wr_busy;
    logic in_clr, out_clr;
    logic ibf, in_req, obf_n, out_req;
    logic [DATA_W-1:0] in_latch, out_q;
    hs_view_t view;
    stat_t    stat;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= 1'b0;
            dir_q  <= 1'b1;
        end else begin
            mode_q <= strobed;
            dir_q  <= dir_in;
        end
    end

    assign cfg_chg = (strobed ^ mode_q) | (dir_in ^ dir_q);
    assign in_clr  = ~(strobed & dir_in) | cfg_chg;
    assign out_clr = ~(strobed & ~dir_in) | cfg_chg;

    shp_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d(hs_n), .q(hs_sync)
    );
    assign hs_low = ~hs_sync;

    shp_edge u_rd_edge (
        .clk(clk), .rst(rst), .lvl(host_rd),
        .start(rd_start), .stop(rd_stop), .busy(rd_busy)
    );
    shp_edge u_wr_edge (
        .clk(clk), .rst(rst), .lvl(host_wr),
        .start(wr_start), .stop(wr_stop), .busy(wr_busy)
    );

    shp_in_hs #(.DATA_W(DATA_W)) u_in (
        .clk(clk), .rst(rst), .clr(in_clr), .stb_low(hs_low),
        .rd_start(rd_start), .rd_stop(rd_stop), .rd_busy(rd_busy),
        .en(intr_en), .din(per_din),
        .ibf(ibf), .req(in_req), .latch(in_latch)
    );

    shp_out_hs u_out (
        .clk(clk), .rst(rst), .clr(out_clr), .ack_low(hs_low),
        .wr_start(wr_start), .wr_stop(wr_stop), .wr_busy(wr_busy),
        .en(intr_en), .obf_n(obf_n), .req(out_req)
    );

    always_ff @(posedge clk) begin
        if (rst)          out_q <= '0;
        else if (host_wr) out_q <= host_wdata;
    end

    assign port_out = out_q;
    assign port_oe  = ~dir_in;
    assign rd_data  = (strobed & dir_in) ? in_latch : per_din;
    assign flag_out = dir_in ? ibf : obf_n;
    assign intr     = strobed & intr_en & (dir_in ? in_req : out_req);

    always_comb begin
        view.flag = flag_out;
        view.en   = intr_en;
        view.req  = intr;
        stat      = place_status(GROUP_A, dir_in, view);
        if (!strobed) begin
            stat.bits = '0;
            stat.mask = '0;
        end
    end

    assign status_bits = stat.bits;
    assign status_mask = stat.mask;

    assert_mask_R8: assert property (@(posedge clk) disable iff (rst)
        strobed |-> ($countones(status_mask) == 3));
    assert_mask_off_R10: assert property (@(posedge clk) disable iff (rst)
        !strobed |-> (status_mask == 8'h00));
    assert_gate_R7: assert property (@(posedge clk) disable iff (rst)
        !intr_en |-> !intr);
endmodule

// File: tb/sim_shp_group.sv
`timescale 1ns/1ps
module sim_shp_group;
    logic clk = 1'b0;
    logic rst, strobed, dir_in, intr_en, host_rd, host_wr, hs_n;
    logic [7:0] host_wdata, per_din;
    logic [7:0] rd_data, port_out, status_bits, status_mask;
    logic [7:0] rd_b, port_b, sbits_b, smask_b;
    logic port_oe, flag_out, intr, oe_b, flag_b, intr_b;
    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    shp_group #(.GROUP_A(1'b1)) u0 (
        .clk(clk), .rst(rst), .strobed(strobed), .dir_in(dir_in),
        .intr_en(intr_en), .host_rd(host_rd), .host_wr(host_wr),
        .host_wdata(host_wdata), .per_din(per_din), .hs_n(hs_n),
        .rd_data(rd_data), .port_out(port_out), .port_oe(port_oe),
        .flag_out(flag_out), .intr(intr),
        .status_bits(status_bits), .status_mask(status_mask));

    shp_group #(.GROUP_A(1'b0)) u1 (
        .clk(clk), .rst(rst), .strobed(strobed), .dir_in(dir_in),
        .intr_en(intr_en), .host_rd(host_rd), .host_wr(host_wr),
        .host_wdata(host_wdata), .per_din(per_din), .hs_n(hs_n),
        .rd_data(rd_b), .port_out(port_b), .port_oe(oe_b),
        .flag_out(flag_b), .intr(intr_b),
        .status_bits(sbits_b), .status_mask(smask_b));

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset;
        rst = 1; strobed = 0; dir_in = 1; intr_en = 0; host_rd = 0;
        host_wr = 0; hs_n = 1; host_wdata = 0; per_din = 0;
        step(3);
        rst = 0;
        step(1);
        chk("R1 flag", {7'b0, flag_out}, 8'h00);
        chk("R1 intr", {7'b0, intr}, 8'h00);
        chk("R1 mask", status_mask, 8'h00);
    endtask

    task automatic host_read;
        host_rd = 1;
        step(1);
        chk("R4 intr cleared at read start", {7'b0, intr}, 8'h00);
        chk("R3 full held during read", {7'b0, flag_out}, 8'h01);
        step(2);
        host_rd = 0;
        step(1);
        chk("R3 full cleared at read end", {7'b0, flag_out}, 8'h00);
        chk("R4 intr stays low", {7'b0, intr}, 8'h00);
    endtask

    task automatic t_input;
        strobed = 1; dir_in = 1; intr_en = 1; per_din = 8'hA5;
        step(3);
        hs_n = 0;
        step(2);
        chk("R2 full not yet at edge 2", {7'b0, flag_out}, 8'h00);
        step(1);
        chk("R2 full at edge 3", {7'b0, flag_out}, 8'h01);
        step(2);
        hs_n = 1;
        step(4);
        per_din = 8'h3C;
        step(1);
        chk("R2 latched data", rd_data, 8'hA5);
        chk("R4 intr after strobe high", {7'b0, intr}, 8'h01);
        chk("R8 status A input", status_bits, 8'h38);
        chk("R8 mask A input", status_mask, 8'h38);
        chk("R9 status B input", sbits_b, 8'h07);
        chk("R9 mask B", smask_b, 8'h07);
        host_read();
    endtask

    task automatic t_gate;
        intr_en = 0;
        hs_n = 0; step(4);
        hs_n = 1; step(4);
        chk("R7 intr low while disabled", {7'b0, intr}, 8'h00);
        chk("R7 full set", {7'b0, flag_out}, 8'h01);
        intr_en = 1;
        step(2);
        chk("R7 intr after late enable", {7'b0, intr}, 8'h01);
        host_read();
    endtask

    task automatic t_clear;
        hs_n = 0; step(4);
        hs_n = 1; step(4);
        chk("R10 full before drop", {7'b0, flag_out}, 8'h01);
        strobed = 0;
        step(1);
        chk("R10 mask off", status_mask, 8'h00);
        step(1);
        strobed = 1;
        step(2);
        chk("R10 full cleared", {7'b0, flag_out}, 8'h00);
        chk("R10 intr cleared", {7'b0, intr}, 8'h00);
    endtask

    task automatic t_output;
        intr_en = 0; dir_in = 0;
        step(3);
        chk("R10 out flag idle high", {7'b0, flag_out}, 8'h01);
        host_wdata = 8'h96; host_wr = 1;
        step(2);
        host_wr = 0;
        step(1);
        chk("R5 obf low after write", {7'b0, flag_out}, 8'h00);
        chk("R5 port data", port_out, 8'h96);
        chk("R5 oe", {7'b0, port_oe}, 8'h01);
        chk("R8 status A output", status_bits, 8'h00);
        chk("R8 mask A output", status_mask, 8'hC8);
        intr_en = 1;
        step(2);
        chk("R8 status A enable", status_bits, 8'h40);
        chk("R9 status B output", sbits_b, 8'h04);
        hs_n = 0;
        step(2);
        chk("R6 obf still low at edge 2", {7'b0, flag_out}, 8'h00);
        step(1);
        chk("R6 obf high at edge 3", {7'b0, flag_out}, 8'h01);
        chk("R6 no intr while ack low", {7'b0, intr}, 8'h00);
        hs_n = 1;
        step(4);
        chk("R6 intr after ack", {7'b0, intr}, 8'h01);
        chk("R8 status A full", status_bits, 8'hC8);
        chk("R9 status B full", sbits_b, 8'h07);
        host_wdata = 8'h2B; host_wr = 1;
        step(1);
        chk("R6 intr cleared at write start", {7'b0, intr}, 8'h00);
        host_wr = 0;
        step(1);
        chk("R5 obf low again", {7'b0, flag_out}, 8'h00);
    endtask

    task automatic t_plain;
        strobed = 0; dir_in = 1; per_din = 8'h5A;
        step(1);
        chk("R11 passthrough", rd_data, 8'h5A);
        chk("R11 oe off", {7'b0, port_oe}, 8'h00);
        per_din = 8'hC3;
        step(1);
        chk("R11 passthrough change", rd_data, 8'hC3);
        dir_in = 0; host_wdata = 8'h11; host_wr = 1;
        step(1);
        host_wr = 0;
        step(1);
        chk("R11 plain write", port_out, 8'h11);
        chk("R11 oe on", {7'b0, port_oe}, 8'h01);
    endtask

    initial begin
        t_reset();
        t_input();
        t_gate();
        t_clear();
        t_output();
        t_plain();
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule